// File: doc/BRIEF.md
# Synthesizer Divider Programming Controller

This block sits between the channel-control logic of a two-way radio and an integer-N frequency synthesizer. A request carries the operating frequency, a channel-step code and a transmit/receive flag. From these the block chooses a reference divider and, with it, a comparison frequency of 5 kHz or 6.25 kHz derived from a 21.25 MHz reference oscillator. It then computes the VCO divide ratio N and shifts both words into the synthesizer over a three-wire serial link: data, clock and a latch strobe.

On receive the VCO runs as a local oscillator 21.7 MHz below the wanted signal, so N is taken from the frequency minus that intermediate frequency. On transmit the VCO sits on the carrier itself. A request whose offset frequency is not a whole multiple of the comparison frequency is refused with an error flag, and nothing is sent. A VCO shift output is high for transmit and for receive inside the aircraft band, so the oscillator can be switched to its other tuning range.

The frequency input counts in steps of 250 Hz (0.25 kHz), so that both comparison frequencies are whole numbers of input steps.

Top module: `synth_prog_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request, busy, err, vco_shift, ser_clk, ser_data and ser_stb are all low.
- R2: Step code 2 (12.5 kHz) selects the 6.25 kHz comparison frequency and sends reference word 3400. Codes 0, 1, 3, 4, 5, 6 and 7 (5, 10, 15, 20, 25, 30 and 50 kHz) select 5 kHz and send 4250.
- R3: With tx_mode high, the N word equals freq_q / 20 for 5 kHz comparison, or freq_q / 25 for 6.25 kHz.
- R4: With tx_mode low, the N word equals (freq_q − 86800) / 20 or (freq_q − 86800) / 25. The value 86800 is 21.7 MHz in 250 Hz units.
- R5: A request is rejected when the offset frequency is not an exact multiple of the comparison frequency, or when a receive frequency lies below 86800. A rejected request sets err, sends no serial activity and ends busy. err stays high until the next request is accepted, and is low after every request that is loaded.
- R6: Each word is sent MSB first, one bit for each rising edge of ser_clk. ser_data changes only while ser_clk is low. A single-cycle ser_stb pulse, with ser_clk low, follows each word. The 14-bit reference word is sent first, then the 16-bit N word.
- R7: After a request is loaded, vco_shift is 1 if tx_mode was high, or if freq_q lies in 472000..543980 (118.000 to 135.995 MHz). Otherwise it is 0. It keeps that value through rejected requests.
- R8: busy rises in the cycle after a request is accepted and falls after the last strobe. A load_req seen while busy is high is ignored: the words sent belong to the first request, and no second load follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_req | input | 1 | Request pulse; accepted when busy is low |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| step_code | input | 3 | Channel step: 0=5, 1=10, 2=12.5, 3=15, 4=20, 5=25, 6=30, 7=50 kHz |
| freq_q | input | 20 | Operating frequency in 250 Hz units |
| busy | output | 1 | Request in progress |
| err | output | 1 | Last accepted request was rejected |
| vco_shift | output | 1 | VCO range shift for transmit or air-band receive |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_stb | output | 1 | Word latch strobe |

## Verification
The bench aims at the edges of the arithmetic. A receive frequency exactly at the intermediate frequency gives N = 0, and one step below it must be refused. A design that wraps the subtraction would instead load a huge N. Frequencies on a 6.25 kHz grid that are off the 5 kHz grid, and the reverse, are refused only with the matching step code, so a wrong step-to-reference mapping shows up as a wrong err or a wrong reference word. The air-band limits are probed one grid step inside and outside on receive, where an off-by-one compare flips vco_shift. A second request placed in the middle of a load checks that the latched values are neither replaced nor followed by an extra word pair.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int unsigned LSB_HZ         = 250;
  localparam int unsigned OSC_HZ         = 21_250_000;
  localparam int unsigned CMP_COARSE_HZ  = 5_000;
  localparam int unsigned CMP_FINE_HZ    = 6_250;
  localparam int unsigned FIRST_IF_HZ    = 21_700_000;
  localparam int unsigned AIR_LO_KHZ     = 118_000;
  localparam int unsigned AIR_HI_KHZ     = 135_995;

  localparam int unsigned REF_DIV_COARSE = OSC_HZ / CMP_COARSE_HZ;
  localparam int unsigned REF_DIV_FINE   = OSC_HZ / CMP_FINE_HZ;
  localparam int unsigned UNITS_COARSE   = CMP_COARSE_HZ / LSB_HZ;
  localparam int unsigned UNITS_FINE     = CMP_FINE_HZ / LSB_HZ;
  localparam int unsigned IF_UNITS       = FIRST_IF_HZ / LSB_HZ;
  localparam int unsigned AIR_LO_UNITS   = AIR_LO_KHZ * (1000 / LSB_HZ);
  localparam int unsigned AIR_HI_UNITS   = AIR_HI_KHZ * (1000 / LSB_HZ);

  typedef enum logic [2:0] {
    STEP_5K    = 3'd0,
    STEP_10K   = 3'd1,
    STEP_12K5  = 3'd2,
    STEP_15K   = 3'd3,
    STEP_20K   = 3'd4,
    STEP_25K   = 3'd5,
    STEP_30K   = 3'd6,
    STEP_50K   = 3'd7
  } step_e;

  typedef enum logic [1:0] {
    SR_IDLE, SR_LOW, SR_HIGH, SR_STB
  } ser_state_e;

  typedef enum logic [2:0] {
    CT_IDLE, CT_CHECK, CT_DIV, CT_REF, CT_NWD
  } ctl_state_e;
endpackage

// File: rtl/synth_ref_sel.sv
module synth_ref_sel
  import synth_pkg::*;
#(
  parameter int RW = 14,
  parameter int UW = 5
) (
  input  logic [2:0]    step_code,
  output logic [RW-1:0] ref_word,
  output logic [UW-1:0] cmp_units
);
  logic fine;

  always_comb begin
    unique case (step_e'(step_code))
      STEP_12K5: fine = 1'b1;
      default:   fine = 1'b0;
    endcase
  end

  always_comb begin
    if (fine) begin
      ref_word  = RW'(REF_DIV_FINE);
      cmp_units = UW'(UNITS_FINE);
    end else begin
      ref_word  = RW'(REF_DIV_COARSE);
      cmp_units = UW'(UNITS_COARSE);
    end
  end
endmodule

// File: rtl/synth_ratio_div.sv
module synth_ratio_div #(
  parameter int DW = 20,
  parameter int VW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quot,
  output logic [VW-1:0] rem
);
  localparam int CNW = $clog2(DW + 1);

  logic [DW-1:0]  q_r, q_n;
  logic [VW-1:0]  r_r, r_n, d_r, d_n;
  logic [CNW-1:0] c_r, c_n;
  logic           run_r, run_n, done_r, done_n;
  logic [VW:0]    trial;
  logic           take;

  always_comb begin
    q_n    = q_r;
    r_n    = r_r;
    d_n    = d_r;
    c_n    = c_r;
    run_n  = run_r;
    done_n = 1'b0;
    trial  = {r_r, q_r[DW-1]};
    take   = (trial >= {1'b0, d_r});
    if (start) begin
      q_n   = dividend;
      r_n   = '0;
      d_n   = divisor;
      c_n   = CNW'(DW);
      run_n = 1'b1;
    end else if (run_r) begin
      if (take) r_n = VW'(trial - {1'b0, d_r});
      else      r_n = trial[VW-1:0];
      q_n = {q_r[DW-2:0], take};
      c_n = c_r - CNW'(1);
      if (c_r == CNW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      c_r    <= '0;
      run_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      q_r    <= q_n;
      r_r    <= r_n;
      d_r    <= d_n;
      c_r    <= c_n;
      run_r  <= run_n;
      done_r <= done_n;
    end
  end

  assign done = done_r;
  assign quot = q_r;
  assign rem  = r_r;

  // R5: exactness test relies on a true remainder below the divisor
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (r_r < d_r));

  // R5: a zero divisor would make every ratio look exact
  p_divisor_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (divisor != '0));
endmodule

// File: rtl/synth_ser_tx.sv
module synth_ser_tx
  import synth_pkg::*;
#(
  parameter  int SW = 16,
  localparam int CW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] word,
  input  logic [CW-1:0] nbits,
  output logic          ser_clk,
  output logic          ser_data,
  output logic          ser_stb,
  output logic          done
);
  ser_state_e    st_r, st_n;
  logic [SW-1:0] sh_r, sh_n;
  logic [CW-1:0] cnt_r, cnt_n;
  logic          done_r, done_n;

  always_comb begin
    st_n   = st_r;
    sh_n   = sh_r;
    cnt_n  = cnt_r;
    done_n = 1'b0;
    unique case (st_r)
      SR_IDLE: begin
        if (start) begin
          sh_n  = word << (CW'(SW) - nbits);
          cnt_n = nbits;
          st_n  = SR_LOW;
        end
      end
      SR_LOW:  st_n = SR_HIGH;
      SR_HIGH: begin
        if (cnt_r == CW'(1)) begin
          st_n = SR_STB;
        end else begin
          sh_n  = {sh_r[SW-2:0], 1'b0};
          cnt_n = cnt_r - CW'(1);
          st_n  = SR_LOW;
        end
      end
      SR_STB: begin
        done_n = 1'b1;
        sh_n   = '0;
        st_n   = SR_IDLE;
      end
      default: st_n = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r   <= SR_IDLE;
      sh_r   <= '0;
      cnt_r  <= '0;
      done_r <= 1'b0;
    end else begin
      st_r   <= st_n;
      sh_r   <= sh_n;
      cnt_r  <= cnt_n;
      done_r <= done_n;
    end
  end

  assign ser_clk  = (st_r == SR_HIGH);
  assign ser_stb  = (st_r == SR_STB);
  assign ser_data = (st_r == SR_LOW || st_r == SR_HIGH) ? sh_r[SW-1] : 1'b0;
  assign done     = done_r;

  // R6: data must hold while the clock is high
  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R6: every strobe hands control back in the next cycle
  p_stb_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |=> (done && !ser_stb));
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_pkg::*;
#(
  parameter  int FW = 20,
  parameter  int NW = 16,
  parameter  int RW = 14,
  parameter  int UW = 5,
  localparam int SW = (RW > NW) ? RW : NW,
  localparam int CW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic          tx_mode,
  input  logic [2:0]    step_code,
  input  logic [FW-1:0] freq_q,
  output logic          busy,
  output logic          err,
  output logic          vco_shift,
  output logic          ser_clk,
  output logic          ser_data,
  output logic          ser_stb
);
  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_ni  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_ni  <= rs_meta;
    end
  end

  ctl_state_e    st_r, st_n;
  logic [FW-1:0] freq_r, freq_n;
  logic [2:0]    step_r, step_n;
  logic          tx_r, tx_n, err_r, err_n, vco_r, vco_n;
  logic          accept, air_r;

  logic [RW-1:0] ref_w;
  logic [UW-1:0] units;
  logic          div_start, div_done;
  logic [FW-1:0] dividend, quot;
  logic [UW-1:0] rem;
  logic          quot_ovf;
  logic          ser_start, ser_done;
  logic [SW-1:0] ser_word;
  logic [CW-1:0] ser_nbits;

  synth_ref_sel #(.RW(RW), .UW(UW)) u_ref (
    .step_code (step_r),
    .ref_word  (ref_w),
    .cmp_units (units)
  );

  assign dividend = tx_r ? freq_r : (freq_r - FW'(IF_UNITS));
  assign air_r    = (freq_r >= FW'(AIR_LO_UNITS)) && (freq_r <= FW'(AIR_HI_UNITS));

  synth_ratio_div #(.DW(FW), .VW(UW)) u_div (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start    (div_start),
    .dividend (dividend),
    .divisor  (units),
    .done     (div_done),
    .quot     (quot),
    .rem      (rem)
  );

  generate
    if (FW > NW) begin : g_ovf
      assign quot_ovf = |quot[FW-1:NW];
    end else begin : g_no_ovf
      assign quot_ovf = 1'b0;
    end
  endgenerate

  assign ser_word  = (st_r == CT_REF) ? SW'(quot[NW-1:0]) : SW'(ref_w);
  assign ser_nbits = (st_r == CT_REF) ? CW'(NW) : CW'(RW);

  synth_ser_tx #(.SW(SW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start    (ser_start),
    .word     (ser_word),
    .nbits    (ser_nbits),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_stb  (ser_stb),
    .done     (ser_done)
  );

  assign accept = load_req && (st_r == CT_IDLE);

  always_comb begin
    st_n      = st_r;
    freq_n    = freq_r;
    step_n    = step_r;
    tx_n      = tx_r;
    err_n     = err_r;
    vco_n     = vco_r;
    div_start = 1'b0;
    ser_start = 1'b0;
    unique case (st_r)
      CT_IDLE: begin
        if (accept) begin
          freq_n = freq_q;
          step_n = step_code;
          tx_n   = tx_mode;
          err_n  = 1'b0;
          st_n   = CT_CHECK;
        end
      end
      CT_CHECK: begin
        if (!tx_r && (freq_r < FW'(IF_UNITS))) begin
          err_n = 1'b1;
          st_n  = CT_IDLE;
        end else begin
          div_start = 1'b1;
          st_n      = CT_DIV;
        end
      end
      CT_DIV: begin
        if (div_done) begin
          if ((rem != '0) || quot_ovf) begin
            err_n = 1'b1;
            st_n  = CT_IDLE;
          end else begin
            vco_n     = tx_r || air_r;
            ser_start = 1'b1;
            st_n      = CT_REF;
          end
        end
      end
      CT_REF: begin
        if (ser_done) begin
          ser_start = 1'b1;
          st_n      = CT_NWD;
        end
      end
      CT_NWD: begin
        if (ser_done) st_n = CT_IDLE;
      end
      default: st_n = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_r   <= CT_IDLE;
      freq_r <= '0;
      step_r <= '0;
      tx_r   <= 1'b0;
      err_r  <= 1'b0;
      vco_r  <= 1'b0;
    end else begin
      st_r   <= st_n;
      freq_r <= freq_n;
      step_r <= step_n;
      tx_r   <= tx_n;
      err_r  <= err_n;
      vco_r  <= vco_n;
    end
  end

  assign busy      = (st_r != CT_IDLE);
  assign err       = err_r;
  assign vco_shift = vco_r;

  // R8: serial lines stay quiet whenever no request is in progress
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!ser_clk && !ser_stb));

  // R8: latched request is not replaced while loading
  p_req_ignored_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> ($stable(freq_r) && $stable(tx_r) && $stable(step_r)));

  // R5: a rejected request never strobes a word
  p_err_no_load_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    err |-> !ser_stb);

  // R7: shift only rises for transmit or the air band
  p_vco_cause_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(vco_shift) |-> (tx_r || air_r));
endmodule

// File: tb/tb_synth_prog_ctrl.sv
`timescale 1ns/1ps
module tb_synth_prog_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_req;
  logic        tx_mode;
  logic [2:0]  step_code;
  logic [19:0] freq_q;
  logic        busy, err, vco_shift, ser_clk, ser_data, ser_stb;

  always #2.5 clk = ~clk;

  synth_prog_ctrl dut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .tx_mode(tx_mode),
    .step_code(step_code), .freq_q(freq_q), .busy(busy), .err(err),
    .vco_shift(vco_shift), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_stb(ser_stb)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_vco = 1'b0;

  int nw, sh, bl, proto_err;
  int wd[4];
  int wl[4];
  bit psc, psd, pst;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int units_of(int s); return (s == 2) ? 25 : 20; endfunction
  function automatic int ref_of(int s);   return (s == 2) ? 3400 : 4250; endfunction
  function automatic int off_of(int f, bit tx); return tx ? f : f - 86800; endfunction
  function automatic bit valid_of(int f, int s, bit tx);
    if (!tx && f < 86800) return 1'b0;
    return ((off_of(f, tx) % units_of(s)) == 0) && ((off_of(f, tx) / units_of(s)) < 65536);
  endfunction
  function automatic bit air_of(int f); return (f >= 472000) && (f <= 543980); endfunction

  task automatic mon_clear();
    nw = 0; sh = 0; bl = 0; proto_err = 0;
    psc = 1'b0; psd = 1'b0; pst = 1'b0;
  endtask

  task automatic mon_sample();
    if (ser_clk && !psc) begin sh = (sh << 1) | int'(ser_data); bl++; end
    if (ser_clk && psc && (ser_data != psd)) proto_err++;
    if (ser_stb && (ser_clk || pst)) proto_err++;
    if (ser_stb) begin
      if (nw < 4) begin wd[nw] = sh; wl[nw] = bl; end
      nw++; sh = 0; bl = 0;
    end
    psc = ser_clk; psd = ser_data; pst = ser_stb;
  endtask

  task automatic run_txn(input int f, input int s, input bit tx, input bit poke);
    bit ok;
    ok = valid_of(f, s, tx);
    freq_q = f[19:0]; step_code = s[2:0]; tx_mode = tx; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    mon_clear();
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    for (int c = 0; c < 400; c++) begin
      if (poke && c == 6) begin
        freq_q = f[19:0] ^ 20'h00155; tx_mode = !tx; load_req = 1'b1;
      end else begin
        load_req = 1'b0;
      end
      @(negedge clk);
      mon_sample();
      if (!busy) break;
    end
    load_req = 1'b0;
    chk(busy == 1'b0, "R8 busy falls", int'(busy), 0);
    chk(err == !ok, "R5 err flag", int'(err), int'(!ok));
    if (ok) begin
      exp_vco = tx || air_of(f);
      chk(nw == 2, "R6 word count", nw, 2);
      chk(wd[0] == ref_of(s), "R2 reference word", wd[0], ref_of(s));
      chk(wl[0] == 14, "R6 reference length", wl[0], 14);
      if (tx) chk(wd[1] == off_of(f, tx) / units_of(s), "R3 tx N word", wd[1], off_of(f, tx) / units_of(s));
      else    chk(wd[1] == off_of(f, tx) / units_of(s), "R4 rx N word", wd[1], off_of(f, tx) / units_of(s));
      chk(wl[1] == 16, "R6 N length", wl[1], 16);
      chk(proto_err == 0, "R6 line protocol", proto_err, 0);
    end else begin
      chk(nw == 0, "R5 no load on reject", nw, 0);
    end
    chk(vco_shift == exp_vco, "R7 vco_shift", int'(vco_shift), int'(exp_vco));
    if (poke) begin
      repeat (4) begin
        @(negedge clk);
        chk(busy == 1'b0, "R8 ignored request started nothing", int'(busy), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_req = 1'b0; tx_mode = 1'b0; step_code = 3'd0; freq_q = '0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(busy == 0 && err == 0 && vco_shift == 0, "R1 reset status", int'({busy, err, vco_shift}), 0);
    chk(ser_clk == 0 && ser_data == 0 && ser_stb == 0, "R1 reset serial", int'({ser_clk, ser_data, ser_stb}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 0 && err == 0, "R1 idle after release", int'({busy, err}), 0);

    // directed cases
    run_txn(580000, 0, 1'b1, 1'b0);  // R3 145.000 MHz tx, 5 kHz
    run_txn(580000, 2, 1'b0, 1'b0);  // R4 145.000 MHz rx, 6.25 kHz
    run_txn(580050, 2, 1'b0, 1'b0);  // R2 12.5 kHz grid accepted
    run_txn(580050, 0, 1'b0, 1'b0);  // R5 off the 5 kHz grid
    run_txn(86800, 0, 1'b0, 1'b0);   // R4 N = 0
    run_txn(86799, 0, 1'b0, 1'b0);   // R5 below the IF
    run_txn(472000, 0, 1'b0, 1'b0);  // R7 air band low edge
    run_txn(471980, 0, 1'b0, 1'b0);  // R7 just below
    run_txn(543980, 0, 1'b0, 1'b0);  // R7 air band high edge
    run_txn(544000, 0, 1'b0, 1'b0);  // R7 just above
    run_txn(580013, 7, 1'b1, 1'b0);  // R5 rejected, vco kept
    run_txn(600000, 5, 1'b1, 1'b1);  // R8 request while busy
    run_txn(500000, 3, 1'b0, 1'b1);  // R8 request while busy, rx

    // constrained random
    for (int i = 0; i < 250; i++) begin
      int s, u, n, f;
      bit tx;
      s  = int'($urandom % 8);
      tx = 1'($urandom % 2);
      u  = units_of(s);
      n  = int'($urandom % 30000);
      f  = (tx ? 0 : 86800) + n * u;
      if (($urandom % 4) == 0) f = f + 1 + int'($urandom % (u - 1));
      if (!tx && ($urandom % 16) == 0) f = int'($urandom % 86800);
      run_txn(f, s, tx, (($urandom % 8) == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule